// File: doc/BRIEF.md
# Bus Transaction Response Phase Generator

This block acts as the response agent of a pipelined processor bus. It watches the transaction at the head of the in-order queue. It waits until every agent has observed the end of that transaction's snoop phase. It then places one 3-bit completion code on the response status lines for a single clock and returns them to idle.

The code depends on four things: the hard-error indication, the snoop outcome (modified hit and defer), the transaction direction with its data need, and a configuration input that allows deferral. A read that returns data also waits until its target is ready and the data bus is free. In the same clock as the code, the block pulses a strobe that pops the queue head.

Top module: `bus_resp_gen`

## Requirements
- R1: Out of reset, and in every cycle without a response, `resp_code` is 3'b000 (idle) and `q_pop` is 0.
- R2: A non-zero code lasts exactly one clock; in the next clock `resp_code` is 3'b000.
- R3: A response is decided at a rising edge where `head_valid`, `snoop_done` are 1 and `resp_code` was 000 in the cycle before that edge; it appears on `resp_code` right after that edge. Without `head_valid` or `snoop_done`, no response is driven.
- R4: With `hard_err` set, the code is 3'b100 (hard failure), whatever the snoop flags, direction or data-bus state.
- R5: With `hard_err` clear and `snp_mod_hit` set, the code is 3'b110 (implicit writeback), for reads and writes, even when `snp_defer` is also set.
- R6: With `hard_err` and `snp_mod_hit` clear and `snp_defer` set, the code is 3'b010 (defer) when `defer_en` is 1, and 3'b001 (retry) when `defer_en` is 0.
- R7: A read (`is_read`=1) with `has_data`=1 and no error or snoop flag gets 3'b111 (normal with data). It is issued only at an edge where `tgt_ready` is 1 and `data_busy` is 0. Until then it waits with `resp_code` at 000.
- R8: A write, or a read with `has_data`=0, with no error or snoop flag gets 3'b101 (normal without data). This does not depend on `data_busy` or `tgt_ready`.
- R9: `q_pop` is 1 in exactly the cycles where `resp_code` is non-zero.
- R10: The reserved code 3'b011 is never driven. When request conditions stay asserted, consecutive responses are separated by at least one idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| head_valid | input | 1 | A transaction sits at the in-order queue head |
| is_read | input | 1 | Head transaction is a read |
| has_data | input | 1 | Head read expects data to be returned |
| snoop_done | input | 1 | All agents have observed snoop-phase completion |
| snp_mod_hit | input | 1 | Snoop result: modified line hit |
| snp_defer | input | 1 | Snoop result: defer requested |
| hard_err | input | 1 | Hard error observed for the head transaction |
| defer_en | input | 1 | Configuration: deferral allowed (else retry) |
| tgt_ready | input | 1 | Addressed target ready to return data |
| data_busy | input | 1 | Data bus currently busy |
| resp_code | output | 3 | Response status code, 000 when idle |
| q_pop | output | 1 | One-cycle pop strobe to the in-order queue |

## Verification
Each code is produced from a transaction that isolates one branch of the priority order. The bench pairs error against modified hit, modified hit against defer, and defer with and without the enable, so a wrongly ordered priority shows up as a wrong code. Reads with data are held behind a busy data bus and then behind a target that is not ready. Writes and no-data reads are issued under a busy bus, which separates the two readiness rules. A request held asserted over several cycles shows both the single-clock width and the idle gap. Missing head-valid or snoop-done shows that the gate stays closed.

// File: rtl/bus_resp_gen.sv
module bus_resp_gen (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       head_valid,
  input  logic       is_read,
  input  logic       has_data,
  input  logic       snoop_done,
  input  logic       snp_mod_hit,
  input  logic       snp_defer,
  input  logic       hard_err,
  input  logic       defer_en,
  input  logic       tgt_ready,
  input  logic       data_busy,
  output logic [2:0] resp_code,
  output logic       q_pop
);
  localparam logic [2:0] RC_IDLE  = 3'b000;
  localparam logic [2:0] RC_RETRY = 3'b001;
  localparam logic [2:0] RC_DEFER = 3'b010;
  localparam logic [2:0] RC_FAIL  = 3'b100;
  localparam logic [2:0] RC_NODAT = 3'b101;
  localparam logic [2:0] RC_IWB   = 3'b110;
  localparam logic [2:0] RC_DATA  = 3'b111;

  logic [2:0] pick;
  logic       want_data, bus_idle, go;

  assign want_data = is_read && has_data;
  assign bus_idle  = (resp_code == RC_IDLE);

  always_comb begin
    if (hard_err)         pick = RC_FAIL;
    else if (snp_mod_hit) pick = RC_IWB;
    else if (snp_defer)   pick = defer_en ? RC_DEFER : RC_RETRY;
    else if (want_data)   pick = RC_DATA;
    else                  pick = RC_NODAT;
  end

  assign go = head_valid && snoop_done && bus_idle &&
              ((pick != RC_DATA) || (tgt_ready && !data_busy));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_code <= RC_IDLE;
      q_pop     <= 1'b0;
    end else begin
      resp_code <= go ? pick : RC_IDLE;
      q_pop     <= go;
    end
  end
endmodule

// File: rtl/bus_resp_gen_chk.sv
module bus_resp_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       head_valid,
  input logic       snoop_done,
  input logic       hard_err,
  input logic       tgt_ready,
  input logic       data_busy,
  input logic [2:0] resp_code,
  input logic       q_pop
);
  p_one_clock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_code != 3'b000) |=> (resp_code == 3'b000));

  p_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_code != 3'b000) |-> $past(head_valid && snoop_done && resp_code == 3'b000));

  p_fail_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((resp_code != 3'b000) && $past(hard_err)) |-> (resp_code == 3'b100));

  p_data_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_code == 3'b111) |-> $past(tgt_ready && !data_busy));

  p_pop_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop == (resp_code != 3'b000));

  p_no_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_code != 3'b011);
endmodule

bind bus_resp_gen bus_resp_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .snoop_done(snoop_done),
  .hard_err(hard_err), .tgt_ready(tgt_ready), .data_busy(data_busy),
  .resp_code(resp_code), .q_pop(q_pop)
);

// File: tb/bus_resp_gen_tb.sv
module bus_resp_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic head_valid = 0, is_read = 0, has_data = 0, snoop_done = 0;
  logic snp_mod_hit = 0, snp_defer = 0, hard_err = 0, defer_en = 0;
  logic tgt_ready = 0, data_busy = 0;
  logic [2:0] resp_code;
  logic q_pop;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_resp_gen u_dut (
    .clk(clk), .rst_n(rst_n), .head_valid(head_valid), .is_read(is_read),
    .has_data(has_data), .snoop_done(snoop_done), .snp_mod_hit(snp_mod_hit),
    .snp_defer(snp_defer), .hard_err(hard_err), .defer_en(defer_en),
    .tgt_ready(tgt_ready), .data_busy(data_busy), .resp_code(resp_code), .q_pop(q_pop)
  );

  task automatic check(input string req, input logic [2:0] code, input logic pop);
    checks++;
    if (resp_code !== code || q_pop !== pop) begin
      fails++;
      $display("FAIL %s: actual code=%b pop=%b expected code=%b pop=%b",
               req, resp_code, q_pop, code, pop);
    end
  endtask

  task automatic clear_all();
    @(negedge clk);
    head_valid = 0; snoop_done = 0; is_read = 0; has_data = 0;
    snp_mod_hit = 0; snp_defer = 0; hard_err = 0; defer_en = 0;
    tgt_ready = 0; data_busy = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic issue(input string req, input logic rd, input logic dat, input logic hm,
                       input logic df, input logic he, input logic de, input logic rdy,
                       input logic bsy, input logic [2:0] exp_code);
    @(negedge clk);
    head_valid = 1; snoop_done = 1; is_read = rd; has_data = dat;
    snp_mod_hit = hm; snp_defer = df; hard_err = he; defer_en = de;
    tgt_ready = rdy; data_busy = bsy;
    step();
    check(req, exp_code, 1'b1);
    clear_all();
    step();
    check("R2", 3'b000, 1'b0);
  endtask

  task automatic t_reset();
    check("R1", 3'b000, 1'b0);
  endtask

  task automatic t_gate_r3();
    @(negedge clk);
    head_valid = 1; snoop_done = 0; is_read = 0;
    step(); step();
    check("R3", 3'b000, 1'b0);
    @(negedge clk);
    head_valid = 0; snoop_done = 1;
    step(); step();
    check("R3", 3'b000, 1'b0);
    clear_all();
  endtask

  task automatic t_priority();
    issue("R4", 1, 1, 1, 1, 1, 1, 0, 1, 3'b100);
    issue("R4", 0, 0, 0, 0, 1, 0, 1, 0, 3'b100);
    issue("R5", 1, 1, 1, 1, 0, 1, 1, 0, 3'b110);
    issue("R5", 0, 0, 1, 0, 0, 0, 0, 1, 3'b110);
    issue("R6", 1, 1, 0, 1, 0, 1, 1, 0, 3'b010);
    issue("R6", 1, 1, 0, 1, 0, 0, 1, 0, 3'b001);
  endtask

  task automatic t_data_wait_r7();
    @(negedge clk);
    head_valid = 1; snoop_done = 1; is_read = 1; has_data = 1;
    tgt_ready = 1; data_busy = 1;
    step(); step(); step();
    check("R7", 3'b000, 1'b0);
    @(negedge clk);
    data_busy = 0; tgt_ready = 0;
    step(); step();
    check("R7", 3'b000, 1'b0);
    @(negedge clk);
    tgt_ready = 1;
    step();
    check("R7", 3'b111, 1'b1);
    clear_all();
    step();
    check("R2", 3'b000, 1'b0);
  endtask

  task automatic t_nodata_r8();
    issue("R8", 0, 1, 0, 0, 0, 0, 0, 1, 3'b101);
    issue("R8", 1, 0, 0, 0, 0, 0, 0, 1, 3'b101);
  endtask

  task automatic t_back_to_back_r10();
    @(negedge clk);
    head_valid = 1; snoop_done = 1; is_read = 0;
    step();
    check("R10", 3'b101, 1'b1);
    step();
    check("R10", 3'b000, 1'b0);
    step();
    check("R10", 3'b101, 1'b1);
    clear_all();
    step();
    check("R9", 3'b000, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1;
    step();
    check("R1", 3'b000, 1'b0);
    t_gate_r3();
    t_priority();
    t_data_wait_r7();
    t_nodata_r8();
    t_back_to_back_r10();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all requirements): actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule